// File: doc/BRIEF.md
# Majority-logic convolutional decoder

This block recovers the information stream of a rate-1/2 systematic convolutional code with memory 6. The generator is g(D) = 1 + D^2 + D^5 + D^6. The code is self-orthogonal, so feedback threshold decoding applies. Each received segment carries one information bit and one parity bit. The two bits arrive on separate inputs together with a strobe. One decoded bit leaves for each segment accepted, so the output rate is half the channel symbol rate.

Inside the block, the received information bits pass through a local re-encoder. Its regenerated parity is XORed with the received parity to form a syndrome bit, which is shifted into a syndrome register. When seven segments are present, four orthogonal check sums decide whether the oldest information bit is in error. These check sums are the syndromes at ages 0, 1, 4 and 6. When at least three of the four are set, that bit is inverted on its way out. The same correction is XORed back into the syndrome stages that still depend on it.

Top module: `mlg_conv_dec`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0. Reset clears the re-encoder and syndrome history, which matches an encoder that starts from the all-zero state.
- R2: For the first six segments accepted after reset, no output is produced: `out_valid` stays 0.
- R3: From the seventh segment on, every accepted segment (`in_valid` high at a rising edge) raises `out_valid` for exactly the following cycle. The bit presented is the information bit of the segment accepted six segments earlier.
- R4: With an error-free input, where parity of segment t is u(t) ^ u(t-2) ^ u(t-5) ^ u(t-6) and missing terms before the start count as 0, `out_bit` equals the transmitted information bits in order.
- R5: Any single flipped bit among all information and parity bits of a stream is corrected.
- R6: Any two flipped bits anywhere in a stream are corrected, because the vote needs at least 3 of the 4 check sums. With fewer than 2 check sums set, no correction is made.
- R7: Cycles with `in_valid` low produce no output and leave the decoder state unchanged, whatever values `data_in` and `parity_in` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A segment is present on data_in and parity_in |
| data_in | input | 1 | Received information bit |
| parity_in | input | 1 | Received parity bit |
| out_valid | output | 1 | out_bit holds a decoded bit this cycle |
| out_bit | output | 1 | Decoded information bit, six segments behind the input |

## Verification
The hardest case to reach from the ports is two errors that both land in the check sums of one decision, while the feedback path still has to cancel an earlier correction. A second case is errors during the first six segments, before the vote is enabled. The bench reaches both with a full sweep: every single-bit and every two-bit error position across both inputs of a 22-segment stream, each stream starting from reset. Expected bits come from the bench's own encoder over a pseudo-random payload. Idle cycles carrying junk data are inserted to show that they are ignored.

// File: rtl/mlcd_pkg.sv
package mlcd_pkg;
  // Code memory and generator; bit j of the generator is the D^j coefficient.
  localparam int unsigned MLCD_MEM = 6;
  localparam logic [MLCD_MEM:0] MLCD_GEN = 7'b110_0101;

  // Number of ones in a vector, zero-extended to 32 bits.
  function automatic int unsigned ones_in(logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // Parity of the history selected by the generator; hist[j] is the bit of age j.
  function automatic logic tap_parity(logic [31:0] hist, logic [31:0] gen);
    return ^(hist & gen);
  endfunction

  // Majority decision over orthogonal check sums.
  function automatic logic vote_of(logic [31:0] checks, int unsigned thr);
    return ones_in(checks) >= thr;
  endfunction
endpackage

// File: rtl/mlcd_reencoder.sv
module mlcd_reencoder #(
  parameter int unsigned MEM = mlcd_pkg::MLCD_MEM,
  parameter logic [MEM:0] GEN = mlcd_pkg::MLCD_GEN
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic info_bit,
  input  logic par_bit,
  output logic syn_bit,
  output logic oldest_info
);
  logic [MEM:1] info_hist;
  logic [MEM:0] hist_now;

  assign hist_now    = {info_hist, info_bit};
  assign syn_bit     = mlcd_pkg::tap_parity(32'(hist_now), 32'(GEN)) ^ par_bit;
  assign oldest_info = info_hist[MEM];

  always_ff @(posedge clk) begin
    if (rst)      info_hist <= '0;
    else if (adv) info_hist <= {info_hist[MEM-1:1], info_bit};
  end
endmodule

// File: rtl/mlcd_syndrome_reg.sv
module mlcd_syndrome_reg #(
  parameter int unsigned MEM = mlcd_pkg::MLCD_MEM,
  parameter logic [MEM:0] GEN = mlcd_pkg::MLCD_GEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         syn_in,
  input  logic         fix,
  output logic [MEM:0] syn_all
);
  logic [MEM:1] stage;

  assign syn_all = {stage, syn_in};

  // Stage k takes the syndrome of age k-1; the correction is folded into every
  // syndrome that still contains the corrected bit (check tap MEM-(k-1)).
  for (genvar k = 1; k <= MEM; k++) begin : g_stage
    localparam bool_fb = GEN[MEM-(k-1)];
    always_ff @(posedge clk) begin
      if (rst)      stage[k] <= 1'b0;
      else if (adv) stage[k] <= syn_all[k-1] ^ (fix & 1'(bool_fb));
    end
  end
endmodule

// File: rtl/mlcd_majority.sv
module mlcd_majority #(
  parameter int unsigned MEM = mlcd_pkg::MLCD_MEM,
  parameter logic [MEM:0] GEN = mlcd_pkg::MLCD_GEN
) (
  input  logic [MEM:0] syn_all,
  input  logic         enable,
  output logic [MEM:0] checks,
  output logic         vote
);
  localparam int unsigned NTAP = mlcd_pkg::ones_in(32'(GEN));
  localparam int unsigned THR  = NTAP / 2 + 1;

  // Syndrome of age k is orthogonal on the oldest bit when tap MEM-k is set.
  for (genvar k = 0; k <= MEM; k++) begin : g_chk
    assign checks[k] = syn_all[k] & GEN[MEM-k];
  end

  assign vote = enable & mlcd_pkg::vote_of(32'(checks), THR);
endmodule

// File: rtl/mlg_conv_dec.sv
module mlg_conv_dec #(
  parameter int unsigned MEM = mlcd_pkg::MLCD_MEM,
  parameter logic [MEM:0] GEN = mlcd_pkg::MLCD_GEN
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic data_in,
  input  logic parity_in,
  output logic out_valid,
  output logic out_bit
);
  localparam int unsigned FW = $clog2(MEM + 1);

  logic [FW-1:0] fill;
  logic          win_full;
  logic          syn_now;
  logic          oldest_info;
  logic [MEM:0]  syn_all;
  logic [MEM:1]  syn_hist;
  logic [MEM:0]  checks;
  logic          vote;
  logic          fix;

  assign win_full = (fill == FW'(MEM));
  assign syn_hist = syn_all[MEM:1];
  assign fix      = vote & in_valid;

  always_ff @(posedge clk) begin
    if (rst)                       fill <= '0;
    else if (in_valid && !win_full) fill <= fill + 1'b1;
  end

  mlcd_reencoder #(.MEM(MEM), .GEN(GEN)) u_reenc (
    .clk(clk), .rst(rst), .adv(in_valid),
    .info_bit(data_in), .par_bit(parity_in),
    .syn_bit(syn_now), .oldest_info(oldest_info)
  );

  mlcd_syndrome_reg #(.MEM(MEM), .GEN(GEN)) u_synd (
    .clk(clk), .rst(rst), .adv(in_valid),
    .syn_in(syn_now), .fix(fix), .syn_all(syn_all)
  );

  mlcd_majority #(.MEM(MEM), .GEN(GEN)) u_vote (
    .syn_all(syn_all), .enable(win_full),
    .checks(checks), .vote(vote)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid & win_full;
      if (in_valid && win_full) out_bit <= oldest_info ^ vote;
    end
  end
endmodule

// File: rtl/mlcd_checker.sv
module mlcd_checker #(
  parameter int unsigned MEM = mlcd_pkg::MLCD_MEM
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         out_valid,
  input logic         win_full,
  input logic         vote,
  input logic [MEM:0] checks,
  input logic [MEM:1] syn_hist
);
  AST_OUT_NEEDS_SEGMENT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R3

  AST_FULL_GIVES_OUT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && win_full) |=> out_valid); // R3

  AST_FILLING_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !win_full) |=> !out_valid); // R2

  AST_IDLE_HOLDS_SYNDROME: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(syn_hist) && $stable(win_full))); // R7

  AST_FEW_CHECKS_NO_VOTE: assert property (@(posedge clk) disable iff (rst)
    ($countones(checks) < 2) |-> !vote); // R6
endmodule

bind mlg_conv_dec mlcd_checker #(.MEM(MEM)) u_mlcd_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .win_full(win_full), .vote(vote), .checks(checks), .syn_hist(syn_hist)
);

// File: tb/test_mlg_conv_dec.sv
module test_mlg_conv_dec;
  localparam int FL = 22;   // segments per stream, tail included
  localparam int DL = 16;   // payload segments
  localparam int DLY = 6;   // decision delay in segments

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic data_in = 1'b0;
  logic parity_in = 1'b0;
  logic out_valid;
  logic out_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  mlg_conv_dec i_mlg_conv_dec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .data_in(data_in),
    .parity_in(parity_in), .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Encode a pseudo-random payload, flip the bits named in ei/ep, decode, compare.
  task automatic run_stream(input logic [FL-1:0] ei, input logic [FL-1:0] ep,
                            input string req, input bit gaps);
    logic [FL-1:0] u;
    logic [FL-1:0] p;
    int taps[4] = '{0, 2, 5, 6};
    for (int k = 0; k < FL; k++) begin
      if (k < DL) begin
        u[k] = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end else u[k] = 1'b0;
    end
    for (int k = 0; k < FL; k++) begin
      p[k] = 1'b0;
      for (int j = 0; j < 4; j++) if (k >= taps[j]) p[k] ^= u[k - taps[j]];
    end
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R1", out_valid, 1'b0, "out_valid in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", out_valid, 1'b0, "out_valid after reset");
    for (int k = 0; k < FL; k++) begin
      in_valid = 1'b1;
      data_in = u[k] ^ ei[k];
      parity_in = p[k] ^ ep[k];
      @(negedge clk);
      if (k >= DLY) begin
        chk("R3", out_valid, 1'b1, $sformatf("out_valid seg %0d", k));
        chk(req, out_bit, u[k - DLY], $sformatf("bit of seg %0d", k - DLY));
      end else begin
        chk("R2", out_valid, 1'b0, $sformatf("out_valid seg %0d", k));
      end
      if (gaps && (k % 3 == 1)) begin
        in_valid = 1'b0; data_in = 1'b1; parity_in = 1'b1;
        @(negedge clk);
        chk("R7", out_valid, 1'b0, "out_valid on idle cycle");
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4: clean streams, with and without idle gaps (R7)
    run_stream('0, '0, "R4", 1'b0);
    run_stream('0, '0, "R7", 1'b1);
    // R5: every single error position on both inputs
    for (int b = 0; b < 2 * FL; b++) begin
      logic [2*FL-1:0] m;
      m = '0; m[b] = 1'b1;
      run_stream(m[FL-1:0], m[2*FL-1:FL], "R5", b[0]);
    end
    // R6: every pair of error positions
    for (int a = 0; a < 2 * FL; a++) begin
      for (int b = a + 1; b < 2 * FL; b++) begin
        logic [2*FL-1:0] m;
        m = '0; m[a] = 1'b1; m[b] = 1'b1;
        run_stream(m[FL-1:0], m[2*FL-1:FL], "R6", ((a + b) % 5) == 0);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule